// File: doc/BRIEF.md
# Statically Scheduled Arithmetic Datapath

This block executes a fixed, compiler-scheduled straight-line program held in a parameter ROM. There are no branches and no hazard logic. The program counter steps through the ROM one word per cycle. Each word names an operation, up to two operand registers (or a small signed immediate), and a destination register for whichever result *completes* in that same cycle. Correct results therefore depend on the schedule matching the unit latencies exactly: one cycle for the single-cycle unit and `MUL_STAGES` cycles for the multiplier.

Operands come from a small data register file, which is loaded from a parameter on reset and keeps its contents across runs. A start pulse launches the program. An input operation samples the input port in its issue cycle. An output operation presents a register on the output port with a one-cycle strobe. When the last ROM word has run, the done flag rises and the block waits for the next start.

Top module: `sched_proc`

## Requirements
- R1: Instruction word layout: opcode in bits [2:0], first field `a` in the next REG_W bits, second field `b` above it, and the destination field `dst` in the top REG_W bits, where REG_W = clog2(RAM_DEPTH). Opcode 1 (add) yields reg[a]+reg[b] and opcode 2 (subtract) yields reg[a]-reg[b], both wrapping modulo 2^DATA_W and completing one cycle after issue.
- R2: Opcode 3 (multiply) yields the low DATA_W bits of reg[a]*reg[b]. It completes exactly MUL_STAGES cycles after issue.
- R3: Opcode 4 (shift) treats field `a` as a signed REG_W-bit amount and shifts reg[b]: positive shifts left, negative shifts arithmetic right. It completes one cycle after issue.
- R4: Opcode 6 (input) captures `in_data` in its issue cycle and completes one cycle later. `in_data` in any other cycle has no effect.
- R5: Opcode 7 (output) drives reg[a] on `out_data` with `out_valid` high for exactly the one cycle after issue. `out_valid` is low in every other cycle.
- R6: The result completing in a cycle is written to register `dst` of that cycle's word. `dst` = 0 writes nothing, so register 0 keeps its reset contents.
- R7: A start pulse clears `done` and sets the program counter to 0. The counter then advances one word per cycle. `done` rises in the cycle after the last word, and the block then stays idle.
- R8: Opcode 5 (copy) yields reg[a] one cycle after issue. Opcode 0 (nop) produces nothing.
- R9: Reset loads the register file from RAM_INIT and clears `done` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the program |
| in_data | input | DATA_W | Value taken by input operations |
| out_data | output | DATA_W | Value presented by output operations |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| done | output | 1 | High once the last program word has run |

## Verification
A fixed scheduled program reads three inputs and derives sum, difference, product, left and right shifts, a copied constant, and a chained product; every result is emitted on the output port. Random operand triples run alongside directed extremes (zero, all-ones, the most negative value, values near overflow). These separate wrap-around from saturation, arithmetic from logical right shift, and low-half from high-half products. The bench changes `in_data` every cycle and checks the exact cycle of each strobe. This catches any input sampled in the wrong cycle and any retirement mis-timed by one cycle. An input whose result retires with destination 0 is followed by a read of register 0, which shows whether the discarded write leaked.

// File: rtl/sched_pkg.sv
package sched_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_MUL   = 3'd3,
    OP_SHIFT = 3'd4,
    OP_COPY  = 3'd5,
    OP_IN    = 3'd6,
    OP_OUT   = 3'd7
  } op_e;

endpackage

// File: rtl/sched_fetch.sv
module sched_fetch #(
  parameter int ROM_DEPTH = 4,
  parameter int WORD_W    = 15,
  parameter int PC_W      = 2,
  parameter logic [ROM_DEPTH*WORD_W-1:0] PROG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              run,
  output logic [PC_W-1:0]   pc,
  output logic              last,
  output logic              done,
  output logic [WORD_W-1:0] word
);

  localparam logic [PC_W-1:0] LAST_PC = PC_W'(ROM_DEPTH - 1);

  assign last = run && (pc == LAST_PC);
  assign word = PROG[int'(pc)*WORD_W +: WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pc   <= '0;
      done <= 1'b0;
    end else if (start) begin
      run  <= 1'b1;
      pc   <= '0;
      done <= 1'b0;
    end else if (run) begin
      if (pc == LAST_PC) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sched_regfile.sv
module sched_regfile #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4,
  parameter logic [DEPTH*DATA_W-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ra,
  input  logic [ADDR_W-1:0] rb,
  output logic [DATA_W-1:0] qa,
  output logic [DATA_W-1:0] qb,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT[i*DATA_W +: DATA_W];
    end else if (we && (int'(wa) < DEPTH)) begin
      mem[wa] <= wd;
    end
  end

  assign qa = (int'(ra) < DEPTH) ? mem[ra] : '0;
  assign qb = (int'(rb) < DEPTH) ? mem[rb] : '0;

endmodule

// File: rtl/sched_alu.sv
module sched_alu
  import sched_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [REG_W-1:0]  imm,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] res_q
);

  function automatic logic [DATA_W-1:0] f_shift(input logic [DATA_W-1:0] v,
                                                input logic [REG_W-1:0] amt);
    int n;
    n = int'($signed(amt));
    if (n >= 0) return v << n;
    return DATA_W'($signed(v) >>> (-n));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else begin
      case (op)
        OP_ADD:   res_q <= opa + opb;
        OP_SUB:   res_q <= opa - opb;
        OP_SHIFT: res_q <= f_shift(opb, imm);
        OP_COPY:  res_q <= opa;
        OP_IN:    res_q <= in_data;
        default:  res_q <= res_q;
      endcase
    end
  end

endmodule

// File: rtl/sched_mulpipe.sv
module sched_mulpipe #(
  parameter int DATA_W = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              issue,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] prod,
  output logic              vld
);

  function automatic logic [DATA_W-1:0] f_mul_lo(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x * y;
  endfunction

  logic [STAGES-1:0][DATA_W-1:0] d_q;
  logic [STAGES-1:0]             v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      v_q <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        if (s == 0) begin
          d_q[s] <= f_mul_lo(a, b);
          v_q[s] <= issue && !flush;
        end else begin
          d_q[s] <= d_q[s-1];
          v_q[s] <= v_q[s-1] && !flush;
        end
      end
    end
  end

  assign prod = d_q[STAGES-1];
  assign vld  = v_q[STAGES-1];

endmodule

// File: rtl/sched_proc.sv
module sched_proc
  import sched_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MUL_STAGES = 2,
  parameter int RAM_DEPTH  = 16,
  parameter int ROM_DEPTH  = 4,
  parameter int REG_W      = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1,
  parameter int WORD_W     = 3 * REG_W + OPC_W,
  parameter logic [ROM_DEPTH*WORD_W-1:0] PROG     = '0,
  parameter logic [RAM_DEPTH*DATA_W-1:0] RAM_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              done
);

  localparam int PC_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  logic              run;
  logic [PC_W-1:0]   pc;
  logic              last;
  logic [WORD_W-1:0] word;

  sched_fetch #(
    .ROM_DEPTH(ROM_DEPTH), .WORD_W(WORD_W), .PC_W(PC_W), .PROG(PROG)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start),
    .run(run), .pc(pc), .last(last), .done(done), .word(word)
  );

  // word fields
  op_e              op;
  logic [REG_W-1:0] f_a;
  logic [REG_W-1:0] f_b;
  logic [REG_W-1:0] f_dst;

  assign op    = op_e'(word[OPC_W-1:0]);
  assign f_a   = word[OPC_W +: REG_W];
  assign f_b   = word[OPC_W + REG_W +: REG_W];
  assign f_dst = word[OPC_W + 2*REG_W +: REG_W];

  op_e issue_op;
  assign issue_op = run ? op : OP_NOP;

  // named events for the checker
  logic issue_mul;
  logic issue_out;
  logic mul_retire;
  logic wr_en;
  logic [REG_W-1:0] wr_addr;

  assign issue_mul = (issue_op == OP_MUL);
  assign issue_out = (issue_op == OP_OUT);

  logic [DATA_W-1:0] qa, qb, alu_res, mul_prod, retire_val;

  sched_alu #(.DATA_W(DATA_W), .REG_W(REG_W)) u_alu (
    .clk(clk), .rst_n(rst_n), .op(issue_op), .opa(qa), .opb(qb),
    .imm(f_a), .in_data(in_data), .res_q(alu_res)
  );

  sched_mulpipe #(.DATA_W(DATA_W), .STAGES(MUL_STAGES)) u_mul (
    .clk(clk), .rst_n(rst_n), .flush(start), .issue(issue_mul),
    .a(qa), .b(qb), .prod(mul_prod), .vld(mul_retire)
  );

  assign retire_val = mul_retire ? mul_prod : alu_res;
  assign wr_en      = run && (f_dst != '0);
  assign wr_addr    = f_dst;

  sched_regfile #(
    .DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .ADDR_W(REG_W), .INIT(RAM_INIT)
  ) u_rf (
    .clk(clk), .rst_n(rst_n), .ra(f_a), .rb(f_b), .qa(qa), .qb(qb),
    .we(wr_en), .wa(wr_addr), .wd(retire_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= issue_out;
      if (issue_out) out_data <= qa;
    end
  end

endmodule

// File: rtl/sched_proc_chk.sv
module sched_proc_chk #(
  parameter int MUL_STAGES = 2,
  parameter int PC_W       = 2,
  parameter int REG_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             run,
  input logic             done,
  input logic             last,
  input logic [PC_W-1:0]  pc,
  input logic             issue_mul,
  input logic             mul_retire,
  input logic             issue_out,
  input logic             out_valid,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_addr
);

  logic [MUL_STAGES-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist <= '0;
    else if (start) hist <= '0;
    else            hist <= (hist << 1) | MUL_STAGES'(issue_mul);
  end

  assert_mul_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mul_retire == hist[MUL_STAGES-1]);

  assert_out_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_out |=> out_valid);

  assert_out_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(issue_out));

  assert_no_zero_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run);

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last && !start) |=> (pc == PC_W'($past(pc) + 1'b1)));

  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run && (pc == '0) && !done));

endmodule

bind sched_proc sched_proc_chk #(
  .MUL_STAGES(MUL_STAGES), .PC_W(PC_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run), .done(done),
  .last(last), .pc(pc), .issue_mul(issue_mul), .mul_retire(mul_retire),
  .issue_out(issue_out), .out_valid(out_valid), .wr_en(wr_en),
  .wr_addr(wr_addr)
);

// File: tb/test_sched_proc.sv
`timescale 1ns/1ps
module test_sched_proc;

  localparam int DW  = 32;
  localparam int RD  = 16;
  localparam int RW  = 4;
  localparam int WW  = 3 * RW + 3;
  localparam int PD  = 24;
  localparam logic [31:0] CONST15 = 32'h1234_5678;
  localparam logic [31:0] INIT0   = 32'hA5A5_0001;

  function automatic logic [WW-1:0] enc(int op, int a, int b, int dst);
    return WW'((dst << (3 + 2*RW)) | (b << (3 + RW)) | (a << 3) | op);
  endfunction

  // opcode: 0 nop,1 add,2 sub,3 mul,4 shift,5 copy,6 in,7 out
  function automatic logic [PD*WW-1:0] build_prog();
    logic [PD*WW-1:0] p;
    p = '0;
    p[0*WW  +: WW] = enc(6, 0, 0, 0);
    p[1*WW  +: WW] = enc(6, 0, 0, 1);
    p[2*WW  +: WW] = enc(6, 0, 0, 2);
    p[3*WW  +: WW] = enc(1, 1, 2, 3);
    p[4*WW  +: WW] = enc(2, 1, 2, 4);
    p[5*WW  +: WW] = enc(3, 1, 3, 5);
    p[6*WW  +: WW] = enc(0, 0, 0, 0);
    p[7*WW  +: WW] = enc(4, 3, 2, 6);
    p[8*WW  +: WW] = enc(4, 14, 3, 7);
    p[9*WW  +: WW] = enc(5, 15, 0, 8);
    p[10*WW +: WW] = enc(7, 4, 0, 9);
    p[11*WW +: WW] = enc(7, 5, 0, 0);
    p[12*WW +: WW] = enc(7, 6, 0, 0);
    p[13*WW +: WW] = enc(7, 7, 0, 0);
    p[14*WW +: WW] = enc(7, 8, 0, 0);
    p[15*WW +: WW] = enc(7, 9, 0, 0);
    p[16*WW +: WW] = enc(3, 4, 5, 0);
    p[17*WW +: WW] = enc(0, 0, 0, 0);
    p[18*WW +: WW] = enc(0, 0, 0, 10);
    p[19*WW +: WW] = enc(7, 10, 0, 0);
    p[20*WW +: WW] = enc(6, 0, 0, 0);
    p[21*WW +: WW] = enc(0, 0, 0, 0);
    p[22*WW +: WW] = enc(7, 0, 0, 0);
    p[23*WW +: WW] = enc(0, 0, 0, 0);
    return p;
  endfunction

  function automatic logic [RD*DW-1:0] build_init();
    logic [RD*DW-1:0] m;
    m = '0;
    m[0*DW  +: DW] = INIT0;
    m[15*DW +: DW] = CONST15;
    return m;
  endfunction

  localparam logic [PD*WW-1:0] PROG_T = build_prog();
  localparam logic [RD*DW-1:0] INIT_T = build_init();

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] out_data;
  logic          out_valid;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sched_proc #(
    .DATA_W(DW), .MUL_STAGES(2), .RAM_DEPTH(RD), .ROM_DEPTH(PD),
    .PROG(PROG_T), .RAM_INIT(INIT_T)
  ) i_sched_proc (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
    .out_data(out_data), .out_valid(out_valid), .done(done)
  );

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mul_lo(logic [DW-1:0] a, logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    return p[DW-1:0];
  endfunction

  task automatic run_prog(logic [DW-1:0] x, logic [DW-1:0] y,
                          logic [DW-1:0] z, logic [DW-1:0] w);
    logic [DW-1:0] exp_v [8];
    int            slot_at [8];
    string         tag [8];
    int            k;
    bit            spurious;
    exp_v[0] = x + y;                          tag[0] = "R1 R4 add";
    exp_v[1] = x - y;                          tag[1] = "R1 sub";
    exp_v[2] = mul_lo(x, z);                   tag[2] = "R2 mul";
    exp_v[3] = {y[DW-4:0], 3'b000};            tag[3] = "R3 left";
    exp_v[4] = {{2{z[DW-1]}}, z[DW-1:2]};      tag[4] = "R3 right";
    exp_v[5] = CONST15;                        tag[5] = "R8 copy";
    exp_v[6] = mul_lo(x + y, x - y);           tag[6] = "R2 chain";
    exp_v[7] = INIT0;                          tag[7] = "R6 R9 reg0";
    slot_at = '{11, 12, 13, 14, 15, 16, 20, 23};
    k = 0;
    spurious = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int idx = 0; idx < 26; idx++) begin
      if (idx > 0) @(negedge clk);
      case (idx)
        0:  in_data = x;
        1:  in_data = y;
        2:  in_data = z;
        20: in_data = w;
        default: in_data = $urandom;
      endcase
      if (idx == 0) check(done == 1'b0, "R7 done cleared", DW'(done), '0);
      if (k < 8 && idx == slot_at[k]) begin
        check(out_valid && (out_data == exp_v[k]), tag[k], out_data, exp_v[k]);
        k++;
      end else if (out_valid) begin
        spurious = 1'b1;
      end
      if (idx == 23) check(done == 1'b0, "R7 done late", DW'(done), '0);
      if (idx == 24) check(done == 1'b1, "R7 done rise", DW'(done), 1);
    end
    check(!spurious, "R5 single strobe", DW'(spurious), '0);
    repeat (4) @(negedge clk);
    check(!out_valid && done, "R7 idle", DW'({out_valid, done}), 1);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!done && !out_valid, "R9 reset", DW'({done, out_valid}), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !out_valid, "R9 after reset", DW'({done, out_valid}), '0);
    run_prog(32'h0, 32'h0, 32'h0, 32'h0);
    run_prog(32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF);
    run_prog(32'h7FFF_FFFF, 32'h1, 32'hFFFF_FFFC, 32'h5);
    run_prog(32'h0001_0000, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0);
    for (int r = 0; r < 30; r++) begin
      logic [DW-1:0] rx, ry, rz, rw;
      rx = $urandom; ry = $urandom; rz = $urandom; rw = $urandom;
      run_prog(rx, ry, rz, rw);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule